// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the feedback division ratio of a fractional-N frequency synthesizer, once for every feedback cycle. A multi-stage cascaded accumulator noise shaper, with selectable order and optional dither, turns a 25-bit fractional word into a small signed offset. The offset is added to a 16-bit integer part to form the divide value for that cycle. The divide value is then split into the two counts that drive a dual-modulus pulse-swallow divider. The main count M is the number of prescaler output pulses in the cycle. The swallow count A is the number of those pulses during which the prescaler divides by P+1 instead of P.

The block runs on the prescaler output clock. It holds its own main and swallow counters and drives the modulus-control line. It also marks the last prescaler pulse of every feedback cycle, and that pulse goes to the phase detector. The prescaler may be a 4/5 or an 8/9 type. The block derives A and M for either type, so the programmed integer and fraction stay the same when the modulus changes. With fractional mode off, the block acts as a plain integer-N divider.

Top module: `fracNDivCtrl`

## Requirements
- R1: With `fracEn` low, every feedback cycle uses a divide value equal to `intPart` exactly. `fracPart`, `orderSel`, `ditherEn` and `ditherRand` have no effect.
- R2: For each cycle, P is 8 when `presSel` is 1 and 4 when it is 0. `mainM` is the divide value divided by P, rounded down. `swallowA` is the remainder. Both are reported with the divide value `divValue`.
- R3: A feedback cycle lasts exactly `mainM` prescaler clocks. `fbPulse` is high only in its last clock. `modCtrl` is high in the first `swallowA` clocks of the cycle and low in the rest.
- R4: In first order (`orderSel`=00) with dither off, the offset for each cycle is the carry out of a 25-bit accumulator that starts at zero after reset and adds `fracPart` once per cycle. Over 2^k cycles with `fracPart` = j·2^(25-k), the divide values sum to exactly 2^k·`intPart` + j.
- R5: `orderSel` codes 00, 01, 10 and 11 select first, second, third and fourth order. For order n the per-cycle offset stays within −(2^(n−1)−1) to 2^(n−1), that is 0..1, −1..2, −3..4 and −7..8. Every order above the first also produces negative offsets.
- R6: For any order with dither off, the sum of offsets over the first W cycles after reset is within 4 of floor(W·`fracPart`/2^25).
- R7: With `ditherEn` high, one LSB is added to the first accumulator each cycle. With `ditherRand` low that LSB is constant 1. With `ditherRand` high it is bit 0 of a 23-bit LFSR. The LFSR is seeded to 1 by reset. In each cycle that uses it, it shifts left and takes bit22 XOR bit17 into bit 0.
- R8: `errFlag` rises when a cycle is loaded with `swallowA` greater than `mainM`. It then stays high until reset.
- R9: During reset `divValue`, `swallowA`, `mainM`, `modCtrl`, `fbPulse` and `errFlag` are all zero. The first clock after reset loads the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| intPart | input | 16 | Integer part of the division ratio |
| fracPart | input | 25 | Fractional part, in units of 2^-25 |
| orderSel | input | 2 | Noise-shaper order: 00 first to 11 fourth |
| ditherEn | input | 1 | Enables dither into the first accumulator |
| ditherRand | input | 1 | 0 for constant dither, 1 for LFSR dither |
| fracEn | input | 1 | Enables fractional operation |
| presSel | input | 1 | Prescaler type: 1 for 8/9, 0 for 4/5 |
| divValue | output | 16 | Divide value of the current cycle |
| swallowA | output | 3 | Swallow count of the current cycle |
| mainM | output | 16 | Main count of the current cycle |
| modCtrl | output | 1 | Modulus control: high selects P+1 |
| fbPulse | output | 1 | High in the last clock of each feedback cycle |
| errFlag | output | 1 | Sticky flag for a swallow count above the main count |

## Verification
`divValue`, `swallowA`, `mainM` and `errFlag` change only on the clock edge that follows a clock in which `fbPulse` is high. The one exception is the first edge after reset. `modCtrl` takes its new cycle value on that same edge. Input changes therefore show up one whole cycle late: inputs applied during a cycle affect only the next load. The bench drives and samples on falling edges. It reads the cycle values at the first falling edge after a load. It then counts clocks and `modCtrl` highs until the falling edge where `fbPulse` is seen. A new scenario starts from a fresh reset, so the first cycle already reflects the new inputs.

// File: rtl/fnDivPkg.sv
package fnDivPkg;
  localparam int SWALLOW_W = 3;

  typedef struct packed {
    logic advance;
  } divStrobe_t;

  typedef enum logic [1:0] {
    ORD_FIRST  = 2'b00,
    ORD_SECOND = 2'b01,
    ORD_THIRD  = 2'b10,
    ORD_FOURTH = 2'b11
  } modOrder_e;
endpackage

// File: rtl/fnModDatapath.sv
module fnModDatapath
  import fnDivPkg::*;
#(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 25,
  parameter int LFSR_W   = 23,
  parameter int LFSR_TAP = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  divStrobe_t           strobe,
  input  logic [INT_W-1:0]     intPart,
  input  logic [FRAC_W-1:0]    fracPart,
  input  logic [1:0]           orderSel,
  input  logic                 ditherEn,
  input  logic                 ditherRand,
  input  logic                 fracEn,
  input  logic                 presSel,
  output logic [SWALLOW_W-1:0] nextA,
  output logic [INT_W-1:0]     nextM,
  output logic [INT_W-1:0]     divValue,
  output logic [SWALLOW_W-1:0] swallowA,
  output logic [INT_W-1:0]     mainM,
  output logic                 errFlag
);
  localparam int NST   = 4;
  localparam int OFF_W = 6;

  logic [FRAC_W-1:0] acc      [NST];
  logic [FRAC_W-1:0] stageSum [NST];
  logic [NST-1:0]    carryNow, hist1, hist2, hist3;
  logic [LFSR_W-1:0] lfsr;
  logic              ditherBit;
  logic signed [OFF_W-1:0] t1, t2, t3, t4, yComb, offset;
  logic [INT_W-1:0]  nextDiv;
  logic              errBad;

  function automatic logic signed [OFF_W-1:0] sb(input logic b);
    return {{(OFF_W-1){1'b0}}, b};
  endfunction

  assign ditherBit = ditherEn & (ditherRand ? lfsr[0] : 1'b1);

  // Cascade of first-order accumulators; each stage integrates the residue of the one before.
  always_comb begin
    for (int s = 0; s < NST; s++) begin
      if (s == 0)
        {carryNow[s], stageSum[s]} = {1'b0, acc[s]} + {1'b0, fracPart}
                                   + {{FRAC_W{1'b0}}, ditherBit};
      else
        {carryNow[s], stageSum[s]} = {1'b0, acc[s]} + {1'b0, stageSum[s-1]};
    end
  end

  // Carry of stage n passes through (1 - z^-1)^(n-1).
  always_comb begin
    t1 = sb(carryNow[0]);
    t2 = sb(carryNow[1]) - sb(hist1[1]);
    t3 = sb(carryNow[2]) - (sb(hist1[2]) <<< 1) + sb(hist2[2]);
    t4 = sb(carryNow[3]) - ((sb(hist1[3]) <<< 1) + sb(hist1[3]))
       + ((sb(hist2[3]) <<< 1) + sb(hist2[3])) - sb(hist3[3]);
    case (modOrder_e'(orderSel))
      ORD_FIRST:  yComb = t1;
      ORD_SECOND: yComb = t1 + t2;
      ORD_THIRD:  yComb = t1 + t2 + t3;
      default:    yComb = t1 + t2 + t3 + t4;
    endcase
    offset  = fracEn ? yComb : '0;
    nextDiv = intPart + {{(INT_W-OFF_W){offset[OFF_W-1]}}, offset};
    nextM   = presSel ? (nextDiv >> 3) : (nextDiv >> 2);
    nextA   = presSel ? nextDiv[2:0] : {1'b0, nextDiv[1:0]};
    errBad  = ({{(INT_W-SWALLOW_W){1'b0}}, nextA} > nextM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divValue <= '0;
      swallowA <= '0;
      mainM    <= '0;
      errFlag  <= 1'b0;
      lfsr     <= {{(LFSR_W-1){1'b0}}, 1'b1};
      hist1    <= '0;
      hist2    <= '0;
      hist3    <= '0;
      for (int s = 0; s < NST; s++) acc[s] <= '0;
    end else if (strobe.advance) begin
      divValue <= nextDiv;
      swallowA <= nextA;
      mainM    <= nextM;
      if (errBad) errFlag <= 1'b1;
      if (fracEn) begin
        for (int s = 0; s < NST; s++) acc[s] <= stageSum[s];
        hist1 <= carryNow;
        hist2 <= hist1;
        hist3 <= hist2;
        if (ditherEn && ditherRand)
          lfsr <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1]};
      end else begin
        for (int s = 0; s < NST; s++) acc[s] <= '0;
        hist1 <= '0;
        hist2 <= '0;
        hist3 <= '0;
      end
    end
  end
endmodule

// File: rtl/fnDivCounter.sv
module fnDivCounter
  import fnDivPkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SWALLOW_W-1:0] nextA,
  input  logic [INT_W-1:0]     nextM,
  output divStrobe_t           strobe,
  output logic                 modCtrl,
  output logic                 fbPulse
);
  logic [INT_W-1:0]     mainCtr;
  logic [SWALLOW_W-1:0] swCtr;
  logic                 started;
  logic                 lastClk;

  assign lastClk        = (mainCtr <= {{(INT_W-1){1'b0}}, 1'b1});
  assign strobe.advance = !started || lastClk;
  assign fbPulse        = started && lastClk;
  assign modCtrl        = (swCtr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mainCtr <= '0;
      swCtr   <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (strobe.advance) begin
        mainCtr <= nextM;
        swCtr   <= nextA;
      end else begin
        mainCtr <= mainCtr - 1'b1;
        if (swCtr != '0) swCtr <= swCtr - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fracNDivCtrl.sv
module fracNDivCtrl
  import fnDivPkg::*;
#(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 25,
  parameter int LFSR_W   = 23,
  parameter int LFSR_TAP = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INT_W-1:0]     intPart,
  input  logic [FRAC_W-1:0]    fracPart,
  input  logic [1:0]           orderSel,
  input  logic                 ditherEn,
  input  logic                 ditherRand,
  input  logic                 fracEn,
  input  logic                 presSel,
  output logic [INT_W-1:0]     divValue,
  output logic [SWALLOW_W-1:0] swallowA,
  output logic [INT_W-1:0]     mainM,
  output logic                 modCtrl,
  output logic                 fbPulse,
  output logic                 errFlag
);
  divStrobe_t           strobe;
  logic [SWALLOW_W-1:0] nextA;
  logic [INT_W-1:0]     nextM;

  fnModDatapath #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)
  ) datapath_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .intPart(intPart), .fracPart(fracPart), .orderSel(orderSel),
    .ditherEn(ditherEn), .ditherRand(ditherRand), .fracEn(fracEn),
    .presSel(presSel), .nextA(nextA), .nextM(nextM),
    .divValue(divValue), .swallowA(swallowA), .mainM(mainM),
    .errFlag(errFlag)
  );

  fnDivCounter #(.INT_W(INT_W)) counter_i (
    .clk(clk), .rst(rst), .nextA(nextA), .nextM(nextM),
    .strobe(strobe), .modCtrl(modCtrl), .fbPulse(fbPulse)
  );
endmodule

// File: rtl/fracNDivCtrl_chk.sv
module fracNDivCtrl_chk
  import fnDivPkg::*;
#(
  parameter int INT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [INT_W-1:0]     intPart,
  input logic                 fracEn,
  input logic [INT_W-1:0]     divValue,
  input logic [SWALLOW_W-1:0] swallowA,
  input logic [INT_W-1:0]     mainM,
  input logic                 modCtrl,
  input logic                 fbPulse,
  input logic                 errFlag
);
  logic [INT_W+2:0] by4, by8, divExt;
  assign by4    = {1'b0, mainM, 2'b00} + {{INT_W{1'b0}}, swallowA};
  assign by8    = {mainM, 3'b000} + {{INT_W{1'b0}}, swallowA};
  assign divExt = {3'b000, divValue};

  assert_integer_exact_R1: assert property (@(posedge clk) disable iff (rst)
    (fbPulse && !fracEn) |=> (divValue == $past(intPart)));

  assert_split_consistent_R2: assert property (@(posedge clk) disable iff (rst)
    (divExt == by4) || (divExt == by8));

  assert_load_modctrl_R3: assert property (@(posedge clk) disable iff (rst)
    fbPulse |=> (modCtrl == (swallowA != '0)));

  assert_modctrl_needs_swallow_R3: assert property (@(posedge clk) disable iff (rst)
    modCtrl |-> (swallowA != '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
endmodule

bind fracNDivCtrl fracNDivCtrl_chk #(.INT_W(INT_W)) chk_i (
  .clk(clk), .rst(rst), .intPart(intPart), .fracEn(fracEn),
  .divValue(divValue), .swallowA(swallowA), .mainM(mainM),
  .modCtrl(modCtrl), .fbPulse(fbPulse), .errFlag(errFlag)
);

// File: tb/fracNDivCtrl_tb_top.sv
`timescale 1ns/1ps
module fracNDivCtrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] intPart = 16'd100;
  logic [24:0] fracPart = '0;
  logic [1:0]  orderSel = 2'b00;
  logic        ditherEn = 1'b0, ditherRand = 1'b0, fracEn = 1'b0, presSel = 1'b1;
  logic [15:0] divValue, mainM;
  logic [2:0]  swallowA;
  logic        modCtrl, fbPulse, errFlag;
  int nChecks = 0;
  int nFail = 0;
  localparam longint FULL = 64'd33554432;

  always #2.5 clk = ~clk;

  fracNDivCtrl dut_i (
    .clk(clk), .rst(rst), .intPart(intPart), .fracPart(fracPart),
    .orderSel(orderSel), .ditherEn(ditherEn), .ditherRand(ditherRand),
    .fracEn(fracEn), .presSel(presSel), .divValue(divValue),
    .swallowA(swallowA), .mainM(mainM), .modCtrl(modCtrl),
    .fbPulse(fbPulse), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Reads one feedback cycle, starting at its first clock; checks R2/R3 consistency.
  task automatic nextCycle(output longint d);
    int clocks = 0;
    int highs = 0;
    longint a, m, expM, expA;
    d = divValue; a = swallowA; m = mainM;
    forever begin
      clocks++;
      if (modCtrl) highs++;
      if (fbPulse) begin @(negedge clk); break; end
      @(negedge clk);
    end
    expM = presSel ? (d >> 3) : (d >> 2);
    expA = presSel ? (d & 7) : (d & 3);
    chk(m == expM, "R2 mainM", m, expM);
    chk(a == expA, "R2 swallowA", a, expA);
    if (a <= m) begin
      chk(clocks == m, "R3 cycle length", clocks, m);
      chk(highs == a, "R3 modCtrl highs", highs, a);
    end
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(divValue == 0, "R9 divValue", divValue, 0);
    chk(swallowA == 0, "R9 swallowA", swallowA, 0);
    chk(mainM == 0, "R9 mainM", mainM, 0);
    chk(modCtrl == 0, "R9 modCtrl", modCtrl, 0);
    chk(fbPulse == 0, "R9 fbPulse", fbPulse, 0);
    chk(errFlag == 0, "R9 errFlag", errFlag, 0);
  endtask

  task automatic tInteger();
    longint d;
    intPart = 16'd100; fracPart = 25'h155AAAA; orderSel = 2'b10;
    ditherEn = 1; ditherRand = 1; fracEn = 0; presSel = 1;
    doReset();
    for (int i = 0; i < 6; i++) begin
      nextCycle(d);
      chk(d == 100, "R1 integer divide 8/9", d, 100);
    end
    intPart = 16'd77; presSel = 0; orderSel = 2'b11; ditherRand = 0;
    doReset();
    for (int i = 0; i < 4; i++) begin
      nextCycle(d);
      chk(d == 77, "R1 integer divide 4/5", d, 77);
    end
    chk(mainM == 19 && swallowA == 1, "R2 split 77/4", mainM, 19);
    intPart = 16'd96; presSel = 1;
    doReset();
    for (int i = 0; i < 3; i++) begin
      nextCycle(d);
      chk(d == 96, "R1 integer divide no swallow", d, 96);
    end
    chk(errFlag == 0, "R8 no error on valid counts", errFlag, 0);
  endtask

  task automatic tFirstOrder();
    longint d, acc, s, c, sum;
    intPart = 16'd100; fracPart = 25'(3 << 22); orderSel = 2'b00;
    ditherEn = 0; fracEn = 1; presSel = 1;
    doReset();
    acc = 0; sum = 0;
    for (int i = 0; i < 16; i++) begin
      s = acc + fracPart; c = s / FULL; acc = s % FULL;
      nextCycle(d);
      chk(d == 100 + c, "R4 first-order carry", d, 100 + c);
      sum += d - 100;
    end
    chk(sum == 6, "R4 exact average over 16 cycles", sum, 6);
  endtask

  task automatic tOrders();
    longint d, off, sum, ideal, mn, mx, lo, hi;
    intPart = 16'd120; fracPart = 25'd12345678; ditherEn = 0; fracEn = 1; presSel = 1;
    ideal = (longint'(512) * 12345678) / FULL;
    for (int o = 0; o < 4; o++) begin
      orderSel = 2'(o);
      doReset();
      sum = 0; mn = 100; mx = -100;
      for (int i = 0; i < 512; i++) begin
        nextCycle(d);
        off = d - 120; sum += off;
        if (off < mn) mn = off;
        if (off > mx) mx = off;
      end
      lo = -((longint'(1) << o) - 1);
      hi = longint'(1) << o;
      chk(mn >= lo, "R5 offset lower bound", mn, lo);
      chk(mx <= hi, "R5 offset upper bound", mx, hi);
      if (o > 0) chk(mn < 0, "R5 higher order gives negative offset", mn, -1);
      chk((sum - ideal <= 4) && (ideal - sum <= 4), "R6 average within bound", sum, ideal);
    end
  endtask

  task automatic tDither();
    longint d, acc, s, c;
    logic [22:0] lf;
    intPart = 16'd100; fracPart = 25'h1FFFFFF; orderSel = 2'b00; fracEn = 1; presSel = 1;
    ditherEn = 1; ditherRand = 0;
    doReset();
    for (int i = 0; i < 8; i++) begin
      nextCycle(d);
      chk(d == 101, "R7 constant dither", d, 101);
    end
    ditherEn = 0;
    doReset();
    nextCycle(d);
    chk(d == 100, "R7 dither disabled first cycle", d, 100);
    nextCycle(d);
    chk(d == 101, "R7 dither disabled second cycle", d, 101);
    ditherEn = 1; ditherRand = 1;
    doReset();
    acc = 0; lf = 23'd1;
    for (int i = 0; i < 48; i++) begin
      s = acc + fracPart + lf[0]; c = s / FULL; acc = s % FULL;
      lf = {lf[21:0], lf[22] ^ lf[17]};
      nextCycle(d);
      chk(d == 100 + c, "R7 LFSR dither", d, 100 + c);
    end
  endtask

  task automatic tError();
    longint d;
    intPart = 16'd20; fracEn = 0; presSel = 1;
    doReset();
    nextCycle(d);
    chk(errFlag == 1, "R8 error on A above M", errFlag, 1);
    intPart = 16'd100;
    nextCycle(d);
    nextCycle(d);
    chk(d == 100, "R8 valid value after change", d, 100);
    chk(errFlag == 1, "R8 error stays set", errFlag, 1);
    doReset();
    chk(errFlag == 0, "R8 error cleared by reset", errFlag, 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    tReset();
    tInteger();
    tFirstOrder();
    tOrders();
    tDither();
    tError();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end
endmodule